// File: doc/BRIEF.md
# CAN Receive Mailbox Register Block

This block sits between a CAN protocol core and a host CPU. The core hands over each completed frame: its 29-bit identifier, extended flag, length code and eight data bytes, together with a mailbox number. The block stores the frame in that mailbox and marks the mailbox full. The host reads the frame back one byte at a time and then frees the mailbox by writing a clear action bit. If a frame lands in a mailbox that is still full, the block overwrites the contents and records an overrun event.

Four event sources feed sticky pending flags: transmit done, frame received, overrun, and error (bus-off or error-passive). Each flag has its own enable, and the single `irq` output is high while any enabled flag is pending. A one-cycle sync pulse can be generated on receive-start or transmit-sync strobes from the core. A two-bit clock prescaler code is held in the setup register and passed to the core unchanged.

Register map, byte wide:

| Address | Register |
|---|---|
| 0x00 | setup |
| 0x01 | action (write-one strobes) |
| 0x02 | pending flags |
| 0x03 | full flags |
| 0x10 + 16·n | mailbox n |

Top module: `canrx_mailbox_regs`

## Requirements
- R1: After reset, the setup, pending, full and action registers read 0x00, and `irq`, `sync_pulse` and `clk_psc` are 0.
- R2: A `rx_done` strobe with `rx_sel` < NUM_MBOX stores the frame into mailbox `rx_sel` and sets its full flag. A strobe with `rx_sel` >= NUM_MBOX stores nothing and raises no event.
- R2 (read layout): Mailbox n is read at offsets from 0x10+16·n:
  - +0: id[28:21]
  - +1: id[20:13]
  - +2: id[12:5]
  - +3: {id[4:0], 3'b000}
  - +4 to +11: data bytes 0 to 7, where byte k is `rx_data[8k+7:8k]`
  - +12: status = {3'b000, dlc[3:0], ext}
  - +13 to +15: read 0
- R3: Every stored frame sets the receive pending flag (bit 1 of 0x02). With receive enable (bit 1 of 0x00) set, `irq` is high in the cycle after the frame.
- R4: A frame stored into a full mailbox sets the overrun pending flag (bit 2). The new frame replaces the old contents, and the full flag stays set.
- R5: Writing 1 to bit n of 0x01 clears the full flag of mailbox n, and 0x01 always reads 0x00. The next frame to that mailbox raises no overrun. A clear in the same cycle as a capture also suppresses the overrun.
- R6: A `tx_done` strobe sets the transmit pending flag (bit 0).
- R7: A rising edge of (`bus_off` | `err_passive`) sets the error pending flag (bit 3). A level that is held high does not set the flag again after it is cleared.
- R8: Pending flags are sticky.
  - Writing 1 to a bit of 0x02 clears that flag.
  - A new event in the same cycle as the clear wins.
  - Flags are set whatever the enables are.
  - `irq` = OR over (pending & enable bits 3:0 of 0x00).
- R9: With bit 4 of 0x00 set, `rx_start` makes `sync_pulse` high for exactly the next cycle. With bit 5 set, `tx_sync` does the same. A source whose bit is clear produces no pulse.
- R10: Bits 7:6 of 0x00 drive `clk_psc` from the cycle after the write and read back unchanged.
- R11: Writing 1 to bit 7 of 0x01 clears all full flags, all mailbox contents and all pending flags. The setup register is left unchanged.
- R12: Bit n of 0x03 reads the full flag of mailbox n. Unmapped addresses, including pages beyond the last mailbox, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational on `reg_addr` |
| rx_done | input | 1 | Core: frame received (one-cycle strobe) |
| rx_sel | input | 3 | Core: target mailbox number |
| rx_id | input | 29 | Core: frame identifier |
| rx_ext | input | 1 | Core: extended-frame flag |
| rx_dlc | input | 4 | Core: data length code |
| rx_data | input | 64 | Core: data bytes, byte 0 in bits 7:0 |
| rx_start | input | 1 | Core: incoming message detected |
| tx_done | input | 1 | Core: transmission completed |
| tx_sync | input | 1 | Core: sync event in the outgoing message |
| bus_off | input | 1 | Core: bus-off state |
| err_passive | input | 1 | Core: error-passive state |
| irq | output | 1 | Combined interrupt |
| sync_pulse | output | 1 | One-cycle sync pulse |
| clk_psc | output | 2 | Prescaler code to the core |

## Verification
Assertions check several rules on every cycle:
- a capture fills the mailbox;
- a full flag is held until a clear or a soft reset;
- a clear releases the mailbox;
- pending flags stay set until written with one, and a new event beats a clear in the same cycle;
- each overrun or stored frame appears as pending;
- a sync pulse follows a source strobe;
- the action register reads zero;
- the prescaler moves only on a setup write.

The directed scenarios show the rest:
- the exact byte order of the identifier, data and status fields;
- that out-of-range mailbox numbers are ignored;
- that the error flag fires once per edge;
- that the enables mask the interrupt but not the pending flags;
- that a soft reset spares the setup register.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

   // event source positions inside the pending and enable vectors
   localparam int EV_TX  = 0;
   localparam int EV_RX  = 1;
   localparam int EV_OVR = 2;
   localparam int EV_ERR = 3;
   localparam int NUM_EV = 4;

   // one mailbox occupies a 16-byte page
   localparam int MB_STRIDE = 16;
   localparam int MB_BYTES  = 13;

   typedef struct packed {
      logic [28:0] id;
      logic        ext;
      logic [3:0]  dlc;
      logic [63:0] data;
   } frame_t;

   typedef struct packed {
      logic [1:0]        psc;
      logic              tsync_en;
      logic              rsync_en;
      logic [NUM_EV-1:0] ien;
   } setup_t;

   // byte view of a stored frame at a page offset
   function automatic logic [7:0] frame_byte(frame_t f, logic [3:0] off);
      logic [7:0] b;
      int         k;
      b = '0;
      k = int'(off) - 4;
      case (off)
         4'd0:  b = f.id[28:21];
         4'd1:  b = f.id[20:13];
         4'd2:  b = f.id[12:5];
         4'd3:  b = {f.id[4:0], 3'b000};
         4'd12: b = {3'b000, f.dlc, f.ext};
         default: begin
            if (k >= 0 && k < 8) b = f.data[k*8 +: 8];
         end
      endcase
      return b;
   endfunction

endpackage

// File: rtl/canrx_mbox.sv
module canrx_mbox
   import canrx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_clr,
   input  logic       cap,
   input  logic       clr,
   input  frame_t     frm_in,
   input  logic       rd_en,
   input  logic [3:0] rd_off,
   output logic       full,
   output logic       ovr_evt,
   output logic [7:0] rd_byte
);

   frame_t frm_q;
   logic   full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_q  <= '0;
         full_q <= 1'b0;
      end else if (soft_clr) begin
         frm_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (cap) frm_q <= frm_in;
         full_q <= cap | (full_q & ~clr);
      end
   end

   assign full    = full_q;
   assign ovr_evt = cap & full_q & ~clr & ~soft_clr;
   assign rd_byte = rd_en ? frame_byte(frm_q, rd_off) : 8'h00;

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !soft_clr) |=> (full && frm_q == $past(frm_in)));

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !cap && !soft_clr) |=> !full);

   p_keep_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr && !soft_clr) |=> full);

   p_soft_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (!full && frm_q == '0));

endmodule

// File: rtl/canrx_evt.sv
module canrx_evt
   import canrx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic [NUM_EV-1:0] set,
   input  logic [NUM_EV-1:0] w1c,
   input  logic [NUM_EV-1:0] ien,
   output logic [NUM_EV-1:0] pend,
   output logic              irq
);

   logic [NUM_EV-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= '0;
      else if (soft_clr) pend_q <= '0;
      else               pend_q <= (pend_q & ~w1c) | set;
   end

   assign pend = pend_q;
   assign irq  = |(pend_q & ien);

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_clr |=> ((($past(pend) & ~$past(w1c)) & ~pend) == '0));

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_clr |=> ((pend & $past(set)) == $past(set)));

   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_clr |=> ((pend & $past(w1c) & ~$past(set)) == '0));

endmodule

// File: rtl/canrx_mailbox_regs.sv
module canrx_mailbox_regs
   import canrx_pkg::*;
#(
   parameter int NUM_MBOX  = 4,
   parameter int ADDR_W    = 8,
   parameter int MBOX_BASE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              rx_done,
   input  logic [2:0]        rx_sel,
   input  logic [28:0]       rx_id,
   input  logic              rx_ext,
   input  logic [3:0]        rx_dlc,
   input  logic [63:0]       rx_data,
   input  logic              rx_start,
   input  logic              tx_done,
   input  logic              tx_sync,
   input  logic              bus_off,
   input  logic              err_passive,
   output logic              irq,
   output logic              sync_pulse,
   output logic [1:0]        clk_psc
);

   localparam int PG_W = ADDR_W - 4;
   localparam logic [PG_W-1:0]   PG0       = PG_W'(MBOX_BASE / MB_STRIDE);
   localparam logic [ADDR_W-1:0] ADR_SETUP = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] ADR_ACT   = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] ADR_PEND  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] ADR_FULL  = ADDR_W'(3);
   localparam int SOFT_BIT = 7;

   // elaboration-time parameter checks
   if (NUM_MBOX < 1 || NUM_MBOX > 7) begin : g_bad_num
      $error("NUM_MBOX must lie in 1..7");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("ADDR_W must be at least 8");
   end
   if (MBOX_BASE < MB_STRIDE || (MBOX_BASE % MB_STRIDE) != 0 ||
       MBOX_BASE + NUM_MBOX * MB_STRIDE > (1 << ADDR_W)) begin : g_bad_base
      $error("MBOX_BASE must be page aligned, above page 0, and fit the address space");
   end

   setup_t              setup_q;
   frame_t              frm;
   logic [NUM_MBOX-1:0] cap_v, clr_v, full_v, ovr_v, rdsel_v;
   logic [7:0]          mb_rd [NUM_MBOX];
   logic [NUM_EV-1:0]   ev_set, ev_w1c, pend;
   logic                soft_clr, we_setup, we_act, we_pend;
   logic                err_now, err_q, sync_q;

   // host write decode
   assign we_setup = reg_wr && (reg_addr == ADR_SETUP);
   assign we_act   = reg_wr && (reg_addr == ADR_ACT);
   assign we_pend  = reg_wr && (reg_addr == ADR_PEND);
   assign soft_clr = we_act && reg_wdata[SOFT_BIT];
   assign ev_w1c   = we_pend ? reg_wdata[NUM_EV-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        setup_q <= '0;
      else if (we_setup) setup_q <= setup_t'(reg_wdata);
   end

   always_comb begin
      frm.id   = rx_id;
      frm.ext  = rx_ext;
      frm.dlc  = rx_dlc;
      frm.data = rx_data;
   end

   // mailbox array
   for (genvar n = 0; n < NUM_MBOX; n++) begin : g_mb
      localparam logic [PG_W-1:0] PG = PG0 + PG_W'(n);

      assign cap_v[n]   = rx_done && (rx_sel == 3'(n));
      assign clr_v[n]   = we_act && reg_wdata[n];
      assign rdsel_v[n] = (reg_addr[ADDR_W-1:4] == PG);

      canrx_mbox u_mb (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_clr (soft_clr),
         .cap      (cap_v[n]),
         .clr      (clr_v[n]),
         .frm_in   (frm),
         .rd_en    (rdsel_v[n]),
         .rd_off   (reg_addr[3:0]),
         .full     (full_v[n]),
         .ovr_evt  (ovr_v[n]),
         .rd_byte  (mb_rd[n])
      );
   end

   // event sources
   assign err_now = bus_off | err_passive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_now;
   end

   always_comb begin
      ev_set         = '0;
      ev_set[EV_TX]  = tx_done;
      ev_set[EV_RX]  = |cap_v;
      ev_set[EV_OVR] = |ovr_v;
      ev_set[EV_ERR] = err_now & ~err_q;
   end

   canrx_evt u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .set      (ev_set),
      .w1c      (ev_w1c),
      .ien      (setup_q.ien),
      .pend     (pend),
      .irq      (irq)
   );

   // sync pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 1'b0;
      else        sync_q <= (setup_q.rsync_en & rx_start) | (setup_q.tsync_en & tx_sync);
   end

   assign sync_pulse = sync_q;
   assign clk_psc    = setup_q.psc;

   // host read mux
   always_comb begin
      logic [7:0] mb_or;
      logic [7:0] full_b;
      mb_or  = '0;
      full_b = '0;
      for (int i = 0; i < NUM_MBOX; i++) begin
         mb_or     = mb_or | mb_rd[i];
         full_b[i] = full_v[i];
      end
      case (reg_addr)
         ADR_SETUP: reg_rdata = setup_q;
         ADR_ACT:   reg_rdata = 8'h00;
         ADR_PEND:  reg_rdata = 8'(pend);
         ADR_FULL:  reg_rdata = full_b;
         default:   reg_rdata = mb_or;
      endcase
   end

   always_comb begin
      if (reg_addr == ADR_ACT) begin
         p_act_reads_zero_r5: assert (reg_rdata == 8'h00);
      end
   end

   p_rx_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cap_v) && !soft_clr) |=> pend[EV_RX]);

   p_ovr_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovr_v) |=> pend[EV_OVR]);

   p_sync_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> $past(rx_start || tx_sync));

   p_psc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_setup |=> $stable(clk_psc));

endmodule

// File: tb/tb_canrx_mailbox_regs.sv
`timescale 1ns/1ps
module tb_canrx_mailbox_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        rx_done = 1'b0;
   logic [2:0]  rx_sel = '0;
   logic [28:0] rx_id = '0;
   logic        rx_ext = 1'b0;
   logic [3:0]  rx_dlc = '0;
   logic [63:0] rx_data = '0;
   logic        rx_start = 1'b0, tx_done = 1'b0, tx_sync = 1'b0;
   logic        bus_off = 1'b0, err_passive = 1'b0;
   logic        irq, sync_pulse;
   logic [1:0]  clk_psc;

   int nvec = 0;
   int nbad = 0;

   always #2 clk = ~clk;   // 250 MHz

   canrx_mailbox_regs dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_done(rx_done),
      .rx_sel(rx_sel), .rx_id(rx_id), .rx_ext(rx_ext), .rx_dlc(rx_dlc),
      .rx_data(rx_data), .rx_start(rx_start), .tx_done(tx_done),
      .tx_sync(tx_sync), .bus_off(bus_off), .err_passive(err_passive),
      .irq(irq), .sync_pulse(sync_pulse), .clk_psc(clk_psc)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
   endtask

   task automatic frame(logic [2:0] sel, logic [28:0] id, logic ext,
                        logic [3:0] dlc, logic [63:0] d);
      @(negedge clk);
      rx_sel = sel; rx_id = id; rx_ext = ext; rx_dlc = dlc; rx_data = d;
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
      #1;
   endtask

   task automatic pulse_tx();
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
      #1;
   endtask

   task automatic chk_mb(int n, logic [28:0] id, logic ext, logic [3:0] dlc,
                         logic [63:0] d, string req);
      logic [7:0] base;
      base = 8'(16 + 16 * n);
      rd(base + 8'd0, id[28:21], req);
      rd(base + 8'd1, id[20:13], req);
      rd(base + 8'd2, id[12:5], req);
      rd(base + 8'd3, {id[4:0], 3'b000}, req);
      for (int k = 0; k < 8; k++) rd(base + 8'(4 + k), d[8*k +: 8], req);
      rd(base + 8'd12, {3'b000, dlc, ext}, req);
   endtask

   task automatic t_reset();
      rd(8'h00, 8'h00, "R1 setup");
      rd(8'h01, 8'h00, "R1 action");
      rd(8'h02, 8'h00, "R1 pending");
      rd(8'h03, 8'h00, "R1 full");
      chk("R1 irq", 8'(irq), 8'h00);
      chk("R1 sync", 8'(sync_pulse), 8'h00);
      chk("R1 psc", 8'(clk_psc), 8'h00);
   endtask

   task automatic t_capture();
      frame(3'd2, 29'h15A3C6E9, 1'b1, 4'd8, 64'h8877665544332211);
      chk_mb(2, 29'h15A3C6E9, 1'b1, 4'd8, 64'h8877665544332211, "R2 layout");
      rd(8'h3D, 8'h00, "R2 offset13");
      rd(8'h03, 8'h04, "R12 full bit2");
   endtask

   task automatic t_bad_sel();
      wr(8'h02, 8'h0F);
      frame(3'd5, 29'h1FFFFFFF, 1'b0, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(8'h03, 8'h04, "R2 bad sel full");
      rd(8'h02, 8'h00, "R2 bad sel pending");
   endtask

   task automatic t_rxirq();
      wr(8'h00, 8'h02);
      frame(3'd1, 29'h00000ABC, 1'b0, 4'd2, 64'h0000_0000_0000_BEEF);
      chk("R3 irq", 8'(irq), 8'h01);
      rd(8'h02, 8'h02, "R3 pending");
      chk_mb(1, 29'h00000ABC, 1'b0, 4'd2, 64'h0000_0000_0000_BEEF, "R2 mb1");
      wr(8'h02, 8'h02);
      chk("R8 irq after w1c", 8'(irq), 8'h00);
      rd(8'h02, 8'h00, "R8 w1c");
   endtask

   task automatic t_overrun();
      frame(3'd2, 29'h0A5A5A5A, 1'b0, 4'd5, 64'h0102030405060708);
      rd(8'h02, 8'h06, "R4 pending");
      rd(8'h03, 8'h06, "R4 full kept");
      chk_mb(2, 29'h0A5A5A5A, 1'b0, 4'd5, 64'h0102030405060708, "R4 overwrite");
   endtask

   task automatic t_clear();
      wr(8'h01, 8'h04);
      rd(8'h03, 8'h02, "R5 cleared");
      rd(8'h01, 8'h00, "R5 action reads 0");
      wr(8'h02, 8'h0F);
      frame(3'd2, 29'h00000001, 1'b1, 4'd1, 64'h77);
      rd(8'h02, 8'h02, "R5 no overrun");
      rd(8'h03, 8'h06, "R5 refilled");
   endtask

   task automatic t_tx();
      wr(8'h00, 8'h00);
      wr(8'h02, 8'h0F);
      pulse_tx();
      rd(8'h02, 8'h01, "R6 pending");
      chk("R8 masked irq", 8'(irq), 8'h00);
      wr(8'h00, 8'h01);
      chk("R8 enable irq", 8'(irq), 8'h01);
      wr(8'h02, 8'h01);
   endtask

   task automatic t_err();
      wr(8'h00, 8'h08);
      @(negedge clk); bus_off = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      rd(8'h02, 8'h08, "R7 pending");
      chk("R7 irq", 8'(irq), 8'h01);
      wr(8'h02, 8'h08);
      repeat (2) @(negedge clk);
      rd(8'h02, 8'h00, "R7 held level");
      @(negedge clk); bus_off = 1'b0;
      @(negedge clk); err_passive = 1'b1;
      @(negedge clk); #1;
      rd(8'h02, 8'h08, "R7 new edge");
      @(negedge clk); err_passive = 1'b0;
      wr(8'h02, 8'h0F);
   endtask

   task automatic t_setwins();
      @(negedge clk);
      rx_sel = 3'd0; rx_id = 29'h123; rx_ext = 1'b0; rx_dlc = 4'd0; rx_data = '0;
      rx_done = 1'b1;
      reg_addr = 8'h02; reg_wdata = 8'h02; reg_wr = 1'b1;
      @(negedge clk);
      rx_done = 1'b0; reg_wr = 1'b0;
      rd(8'h02, 8'h02, "R8 set wins");
   endtask

   task automatic t_sync();
      wr(8'h00, 8'h10);
      @(negedge clk); rx_start = 1'b1;
      @(negedge clk); rx_start = 1'b0; #1;
      chk("R9 rx pulse", 8'(sync_pulse), 8'h01);
      @(negedge clk); #1;
      chk("R9 pulse ends", 8'(sync_pulse), 8'h00);
      @(negedge clk); tx_sync = 1'b1;
      @(negedge clk); tx_sync = 1'b0; #1;
      chk("R9 tx disabled", 8'(sync_pulse), 8'h00);
      wr(8'h00, 8'h20);
      @(negedge clk); tx_sync = 1'b1;
      @(negedge clk); tx_sync = 1'b0; #1;
      chk("R9 tx pulse", 8'(sync_pulse), 8'h01);
   endtask

   task automatic t_psc();
      wr(8'h00, 8'hC0);
      chk("R10 psc 3", 8'(clk_psc), 8'h03);
      rd(8'h00, 8'hC0, "R10 readback");
      wr(8'h00, 8'h40);
      chk("R10 psc 1", 8'(clk_psc), 8'h01);
   endtask

   task automatic t_soft();
      pulse_tx();
      wr(8'h01, 8'h80);
      rd(8'h03, 8'h00, "R11 full");
      rd(8'h02, 8'h00, "R11 pending");
      rd(8'h30, 8'h00, "R11 contents");
      rd(8'h3C, 8'h00, "R11 status");
      rd(8'h00, 8'h40, "R11 setup kept");
   endtask

   task automatic t_unmapped();
      rd(8'h05, 8'h00, "R12 gap");
      rd(8'h50, 8'h00, "R12 beyond last mailbox");
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      nvec++;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_capture();
      t_bad_sel();
      t_rxirq();
      t_overrun();
      t_clear();
      t_tx();
      t_err();
      t_setwins();
      t_sync();
      t_psc();
      t_soft();
      t_unmapped();
      report();
   end

endmodule